// File: doc/BRIEF.md
# Four-Entry Master Data Buffer

This block is a small byte store that sits between a register bus and an I2C master sequencer. The host side sees a single data register: writing it appends a transmit byte, reading it takes the oldest byte and moves the remaining bytes one place toward the front. An empty read returns 0xFF. A write into a full store is dropped without any indication.

The sequencer side sees the store as an array. It can write any slot by index. It can also set the fill level directly when a receive transfer ends, so the host can then pop the bytes that were collected.

Two flags follow the fill level: one says at least one byte is held, the other says all four are held. A flush input empties and zeroes the store in one cycle.

Top module: `mdbuf`

## Requirements
- R1: After reset, `level` is 0, both flags are 0, every byte of `entries` is 0, and `host_rdata` reads 0xFF.
- R2: A host write with `level` below 4 stores `host_wdata` at slot `level` (byte `level` of `entries`, bits 8*i+7:8*i hold slot i) and raises `level` by one.
- R3: A host write with `level` equal to 4 is dropped: `level`, the flags and every slot are unchanged.
- R4: With `level` above 0, `host_rdata` shows slot 0. A host read moves each slot i+1 into slot i, clears slot 3 and lowers `level` by one.
- R5: With `level` equal to 0, `host_rdata` is 0xFF and a host read changes no state.
- R6: `buf_avail` is 1 exactly when `level` is not 0, and `buf_full` is 1 exactly when `level` is 4. Both update in the same cycle as `level`.
- R7: `flush` sets `level` to 0, zeroes every slot and clears both flags. It overrides every other request in that cycle.
- R8: A host read and a host write in the same cycle apply the read first and then the write. At `level` 4 the write therefore lands, and at `level` 0 the read returns 0xFF and the write still lands.
- R9: `seq_we` writes `seq_wdata` into slot `seq_idx` without changing `level` or the flags.
- R10: `seq_load` sets `level` to `seq_cnt`, clamped to 4, and sets the flags to match. Host reads and writes are ignored in any cycle with `seq_we` or `seq_load` asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host push request |
| host_wdata | input | 8 | Byte to push |
| host_rd | input | 1 | Host pop request |
| host_rdata | output | 8 | Front byte, or 0xFF when empty |
| flush | input | 1 | Empty and zero the store |
| seq_we | input | 1 | Sequencer slot write |
| seq_idx | input | 2 | Slot index for the sequencer write |
| seq_wdata | input | 8 | Byte for the sequencer write |
| seq_load | input | 1 | Load the fill level from the sequencer |
| seq_cnt | input | 3 | Bytes completed by the transfer |
| level | output | 3 | Number of bytes held (0 to 4) |
| buf_avail | output | 1 | At least one byte held |
| buf_full | output | 1 | Four bytes held |
| entries | output | 32 | All four slots, slot i in bits 8*i+7:8*i |

## Verification
A wrong fill level appears on the cycle after the faulty update. It shows on `level` and on the flags, and it also moves the next push to the wrong byte of `entries`. A slot that is shifted or cleared wrongly shows in `entries` after that same edge, and on `host_rdata` once that slot reaches the front. The reference model compares every output on every cycle, including long random runs that mix flushes, loads and simultaneous requests. Any divergence is therefore reported within one clock of the edge that caused it.

// File: rtl/mdbuf.sv
module mdbuf #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_wr,
  input  logic [W-1:0]     host_wdata,
  input  logic             host_rd,
  output logic [W-1:0]     host_rdata,
  input  logic             flush,
  input  logic             seq_we,
  input  logic [IW-1:0]    seq_idx,
  input  logic [W-1:0]     seq_wdata,
  input  logic             seq_load,
  input  logic [CW-1:0]    seq_cnt,
  output logic [CW-1:0]    level,
  output logic             buf_avail,
  output logic             buf_full,
  output logic [W*DEPTH-1:0] entries
);

  logic [W-1:0]  mem  [DEPTH];
  logic [W-1:0]  nmem [DEPTH];
  logic [CW-1:0] cnt, ncnt;
  logic          avail_q, full_q;

  wire host_ok = !flush && !seq_we && !seq_load;

  always_comb begin
    nmem = mem;
    ncnt = cnt;
    if (flush) begin
      for (int i = 0; i < DEPTH; i++) nmem[i] = '0;
      ncnt = '0;
    end else if (!host_ok) begin
      if (seq_we) nmem[seq_idx] = seq_wdata;
      if (seq_load) ncnt = (seq_cnt > CW'(DEPTH)) ? CW'(DEPTH) : seq_cnt;
    end else begin
      if (host_rd && cnt != '0) begin
        for (int i = 0; i < DEPTH - 1; i++) nmem[i] = mem[i+1];
        nmem[DEPTH-1] = '0;
        ncnt = cnt - 1'b1;
      end
      if (host_wr && ncnt != CW'(DEPTH)) begin
        nmem[ncnt[IW-1:0]] = host_wdata;
        ncnt = ncnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      cnt     <= '0;
      avail_q <= 1'b0;
      full_q  <= 1'b0;
    end else begin
      mem     <= nmem;
      cnt     <= ncnt;
      avail_q <= (ncnt != '0);
      full_q  <= (ncnt == CW'(DEPTH));
    end
  end

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_flat
      assign entries[g*W +: W] = mem[g];
    end
  endgenerate

  assign host_rdata = (cnt == '0) ? {W{1'b1}} : mem[0];
  assign level      = cnt;
  assign buf_avail  = avail_q;
  assign buf_full   = full_q;

  a_r5_empty_read_stable: assert property (@(posedge clk) disable iff (!rst_n)
    host_ok && host_rd && !host_wr && level == '0
    |=> level == '0 && $stable(entries));

  a_r3_full_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    host_ok && host_wr && !host_rd && buf_full
    |=> buf_full && $stable(entries) && $stable(level));

  a_r4_pop_decrements: assert property (@(posedge clk) disable iff (!rst_n)
    host_ok && host_rd && !host_wr && level != '0
    |=> level == $past(level) - 1'b1);

  a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> level == '0 && entries == '0 && !buf_avail && !buf_full);

  a_r10_load_level: assert property (@(posedge clk) disable iff (!rst_n)
    !flush && seq_load
    |=> level == (($past(seq_cnt) > CW'(DEPTH)) ? CW'(DEPTH) : $past(seq_cnt)));

  a_r6_flags_track: assert property (@(posedge clk) disable iff (!rst_n)
    buf_avail == (level != '0) && buf_full == (level == CW'(DEPTH)));

endmodule

// File: tb/mdbuf_test.sv
module mdbuf_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic host_wr = 0, host_rd = 0, flush = 0, seq_we = 0, seq_load = 0;
  logic [7:0] host_wdata = 0, seq_wdata = 0;
  logic [1:0] seq_idx = 0;
  logic [2:0] seq_cnt = 0;
  logic [7:0] host_rdata;
  logic [2:0] level;
  logic buf_avail, buf_full;
  logic [31:0] entries;

  int errors = 0, checks = 0;
  int m[4];
  int c;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdbuf uut (.clk, .rst_n, .host_wr, .host_wdata, .host_rd, .host_rdata,
             .flush, .seq_we, .seq_idx, .seq_wdata, .seq_load, .seq_cnt,
             .level, .buf_avail, .buf_full, .entries);

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    chk(tag, "level", level, c);
    chk("R6", "avail", buf_avail, c != 0);
    chk("R6", "full", buf_full, c == 4);
    for (int i = 0; i < 4; i++) chk(tag, "slot", entries[i*8 +: 8], m[i]);
    chk(tag, "rdata", host_rdata, c == 0 ? 8'hFF : m[0]);
  endtask

  task automatic step(string tag, bit wr, int wd, bit rd, bit fl,
                      bit swe, int si, int sd, bit sld, int sc);
    host_wr = wr; host_wdata = 8'(wd); host_rd = rd; flush = fl;
    seq_we = swe; seq_idx = 2'(si); seq_wdata = 8'(sd);
    seq_load = sld; seq_cnt = 3'(sc);
    #1;
    chk(tag, "rdata_pre", host_rdata, c == 0 ? 8'hFF : m[0]);
    if (fl) begin
      for (int i = 0; i < 4; i++) m[i] = 0;
      c = 0;
    end else if (swe || sld) begin
      if (swe) m[si] = sd & 8'hFF;
      if (sld) c = (sc > 4) ? 4 : sc;
    end else begin
      if (rd && c > 0) begin
        for (int i = 0; i < 3; i++) m[i] = m[i+1];
        m[3] = 0;
        c--;
      end
      if (wr && c < 4) begin
        m[c] = wd & 8'hFF;
        c++;
      end
    end
    @(posedge clk);
    @(negedge clk);
    host_wr = 0; host_rd = 0; flush = 0; seq_we = 0; seq_load = 0;
    compare(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) m[i] = 0;
    c = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    compare("R1");
    // R2 pushes
    step("R2", 1, 8'h11, 0, 0, 0, 0, 0, 0, 0);
    step("R2", 1, 8'h22, 0, 0, 0, 0, 0, 0, 0);
    step("R2", 1, 8'h33, 0, 0, 0, 0, 0, 0, 0);
    step("R2", 1, 8'h44, 0, 0, 0, 0, 0, 0, 0);
    // R3 overflow dropped
    step("R3", 1, 8'h55, 0, 0, 0, 0, 0, 0, 0);
    // R8 simultaneous at full
    step("R8", 1, 8'h66, 1, 0, 0, 0, 0, 0, 0);
    // R4 pops
    for (int k = 0; k < 4; k++) step("R4", 0, 0, 1, 0, 0, 0, 0, 0, 0);
    // R5 empty read
    step("R5", 0, 0, 1, 0, 0, 0, 0, 0, 0);
    // R8 simultaneous at empty and at one
    step("R8", 1, 8'h77, 1, 0, 0, 0, 0, 0, 0);
    step("R8", 1, 8'h88, 1, 0, 0, 0, 0, 0, 0);
    // R7 flush over a push
    step("R2", 1, 8'h99, 0, 0, 0, 0, 0, 0, 0);
    step("R7", 1, 8'hAA, 1, 1, 1, 2, 8'hBB, 1, 3);
    // R9 direct slot writes
    step("R9", 0, 0, 0, 0, 1, 0, 8'hC0, 0, 0);
    step("R9", 0, 0, 0, 0, 1, 3, 8'hC3, 0, 0);
    step("R9", 0, 0, 0, 0, 1, 1, 8'hC1, 0, 0);
    // R10 load with host ops ignored, clamp
    step("R10", 1, 8'hEE, 1, 0, 1, 2, 8'hC2, 1, 2);
    step("R4", 0, 0, 1, 0, 0, 0, 0, 0, 0);
    step("R10", 0, 0, 0, 0, 0, 0, 0, 1, 7);
    step("R10", 0, 0, 0, 0, 0, 0, 0, 1, 0);
    step("R10", 1, 8'h12, 0, 0, 1, 1, 8'h34, 0, 0);
    step("R10", 0, 0, 0, 0, 0, 0, 0, 1, 4);
    // random mix
    for (int k = 0; k < 2000; k++) begin
      int r = $urandom_range(0, 99);
      step("R6", $urandom_range(0, 1), $urandom_range(0, 255),
           $urandom_range(0, 1), r < 4, r >= 4 && r < 12,
           $urandom_range(0, 3), $urandom_range(0, 255),
           r >= 10 && r < 16, $urandom_range(0, 7));
    end
    rst_n = 0;
    @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < 4; i++) m[i] = 0;
    c = 0;
    compare("R1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule